// File: doc/BRIEF.md
# One-Time-Programmable Bit Array

This block is a synthesizable behavioural model of a one-time-programmable memory. One set of cells is seen two ways: programming addresses a single bit, reading returns a whole byte. Every cell leaves manufacture holding 1. Programming can only move a cell to 0, and nothing can move it back. The array depth is a parameter, so simulations can run on a small array while the address split stays the same.

A controller selects the block with an active-low chip enable. It loads the bit to program from a serial input while a latch enable is high. It then applies program pulses: cycles with the program enable high, the active-low write strobe low and the read enable low. A weak cell takes a configurable number of consecutive pulses to the same address before it clears. This lets a controller model the program-then-verify loop. Reads return one byte a clock after the read cycle, and the output holds that byte until the next read. Reset clears the latched program bit and the output register. The cells themselves are non-volatile and keep their contents through reset.

Top module: `otp_bitarray`

## Requirements
- R1: During reset (`rst_n` low at a clock edge) `dout` becomes 8'h00 and the latched program bit becomes 1. Pulses after reset with no new latch therefore change no cell.
- R2: A cell that has never been programmed reads as 1. A fresh byte reads 8'hFF.
- R3: A read cycle is a clock edge with `ce_n`=0, `rd_en`=1 and `we_n`=1. After that edge `dout` holds the byte selected by `addr[ADDR_W-1:3]`. The low three address bits play no part in a read.
- R4: After any edge that is not a read cycle, `dout` keeps its previous value.
- R5: Program address `addr` names bit `addr[2:0]` of byte `addr[ADDR_W-1:3]`. When that cell clears, that bit position reads 0.
- R6: A program pulse is an edge with `ce_n`=0, `pgm_en`=1, `we_n`=0 and `rd_en`=0. With `we_n`=1 or `rd_en`=1 no cell changes, and with `rd_en`=1 and `we_n`=0 no read takes place either.
- R7: With a latched 0, a cell clears on the PULSES-th consecutive program pulse to the same address. A pulse to a different address, or a pulse with a latched 1, restarts the count. Pulses separated only by non-pulse cycles still count as consecutive.
- R8: With a latched 1, pulses change nothing. A cleared cell never returns to 1.
- R9: The program bit is captured from `din` at an edge where `dle`=1 and `ce_n`=0. At other edges it holds.
- R10: While `ce_n`=1 no read, pulse or latch takes effect, and `dout` holds.
- R11: Reset does not alter the cells. Programmed bits read back the same after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low; high means standby |
| rd_en | input | 1 | Read enable; must be low to program |
| pgm_en | input | 1 | Program enable |
| we_n | input | 1 | Write strobe, active low; high inhibits programming |
| din | input | 1 | Serial program data bit |
| dle | input | 1 | Captures `din` into the program bit latch |
| addr | input | ADDR_W | Bit address for programming; upper ADDR_W-3 bits are the byte address for reads |
| dout | output | 8 | Registered read byte |

## Verification
A read cycle puts its byte on `dout` at that same clock edge, so the result is due one edge after the read is issued. A pulse that clears a cell changes storage at its own edge, and the change becomes visible only through a later read cycle. The bench drives all inputs just after a rising edge. At each rising edge it advances a reference model built from the requirements, then compares `dout` with the model 1 ns later. Directed sequences place a read straight after each series of pulses so that every burned or unburned bit shows up at the port.

// File: rtl/otp_pkg.sv
// Shared types for the one-time-programmable bit array.
package otp_pkg;
    // Operation decoded from the control pins for one clock edge.
    typedef enum logic [1:0] {
        OP_STANDBY = 2'd0,
        OP_IDLE    = 2'd1,
        OP_READ    = 2'd2,
        OP_PROG    = 2'd3
    } otp_op_e;
endpackage

// File: rtl/otp_mode_decode.sv
// Decodes the control pins into one operation per cycle.
// Assumes pins are synchronous to clk; purely combinational.
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic    ce_n,
    input  logic    rd_en,
    input  logic    pgm_en,
    input  logic    we_n,
    output otp_op_e op
);
    // Standby wins, then read (needs strobe high), then program (needs read low).
    always_comb begin
        if (ce_n)
            op = OP_STANDBY;
        else if (rd_en && we_n)
            op = OP_READ;
        else if (!rd_en && pgm_en && !we_n)
            op = OP_PROG;
        else
            op = OP_IDLE;
    end
endmodule

// File: rtl/otp_data_latch.sv
// One-bit program data buffer loaded from the serial input.
// Reset loads 1 so that no stale 0 can burn a cell.
module otp_data_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic din,
    output logic bit_q
);
    // Capture din when enabled; reset to the harmless value 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_q <= 1'b1;
        else if (capture)
            bit_q <= din;
    end
endmodule

// File: rtl/otp_pulse_tracker.sv
// Counts consecutive program pulses to one bit address carrying a 0.
// Raises burn_en on the pulse that reaches PULSES. A pulse to another
// address restarts at 1; a pulse with data 1 clears the count.
module otp_pulse_tracker #(
    parameter int ADDR_W = 10,
    parameter int PULSES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse,
    input  logic              zero_req,
    input  logic [ADDR_W-1:0] addr,
    output logic              burn_en
);
    localparam int CNT_W = $clog2(PULSES + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] last_q;
    logic [CNT_W-1:0]  cnt_nxt;

    // Next count: continue the run on the same address, else start over.
    always_comb begin
        if (cnt_q != '0 && addr == last_q)
            cnt_nxt = cnt_q + CNT_W'(1);
        else
            cnt_nxt = CNT_W'(1);
    end

    assign burn_en = pulse && zero_req && (cnt_nxt >= CNT_W'(PULSES));

    // Track run length and address of the current pulse series.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else if (pulse) begin
            if (!zero_req)
                cnt_q <= '0;
            else if (burn_en)
                cnt_q <= '0;
            else
                cnt_q <= cnt_nxt;
            last_q <= addr;
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(PULSES));
endmodule

// File: rtl/otp_cell_array.sv
// Cell storage seen bit-wide for programming and byte-wide for reading.
// Stores a "burned" flag per cell (1 = programmed to 0), starting all
// clear; the flags are non-volatile and ignore reset. The read byte is
// registered and holds between reads.
module otp_cell_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burn_en,
    input  logic [ADDR_W-1:0] burn_addr,
    input  logic              rd_go,
    input  logic [ADDR_W-4:0] rd_byte,
    output logic [7:0]        rdata_q
);
    localparam int NBITS  = 1 << ADDR_W;
    localparam int NBYTES = NBITS / 8;

    logic [NBITS-1:0] burn_q = '0;
    logic [7:0]       bytes [NBYTES];

    // Present each byte as stored logic levels (unburned cell = 1).
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign bytes[b] = ~burn_q[b*8 +: 8];
    end

    // Burn one addressed cell; cells are never restored.
    always_ff @(posedge clk) begin
        if (burn_en)
            burn_q[burn_addr] <= 1'b1;
    end

    // Register the selected byte on a read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= 8'h00;
        else if (rd_go)
            rdata_q <= bytes[rd_byte];
    end

    // R8
    one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(burn_q) & ~burn_q) == '0);
    // R5
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(burn_q ^ $past(burn_q)) <= 1);
    // R4
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rdata_q));
endmodule

// File: rtl/otp_bitarray.sv
// Top of the one-time-programmable bit array: bit-wide program path,
// byte-wide registered read path over the same cells.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module otp_bitarray #(
    parameter int ADDR_W = 10,
    parameter int PULSES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              rd_en,
    input  logic              pgm_en,
    input  logic              we_n,
    input  logic              din,
    input  logic              dle,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        dout
);
    import otp_pkg::*;

    localparam int BYTE_AW = ADDR_W - 3;

    otp_op_e op_w;
    logic    data_bit;
    logic    burn_w;

    otp_mode_decode u_decode (
        .ce_n   (ce_n),
        .rd_en  (rd_en),
        .pgm_en (pgm_en),
        .we_n   (we_n),
        .op     (op_w)
    );

    otp_data_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (dle && !ce_n),
        .din     (din),
        .bit_q   (data_bit)
    );

    otp_pulse_tracker #(
        .ADDR_W (ADDR_W),
        .PULSES (PULSES)
    ) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse    (op_w == OP_PROG),
        .zero_req (!data_bit),
        .addr     (addr),
        .burn_en  (burn_w)
    );

    otp_cell_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .burn_en   (burn_w),
        .burn_addr (addr),
        .rd_go     (op_w == OP_READ),
        .rd_byte   (addr[ADDR_W-1:ADDR_W-BYTE_AW]),
        .rdata_q   (dout)
    );

    // R6
    burn_needs_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burn_w |-> (!ce_n && pgm_en && !we_n && !rd_en));
    // R10
    standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> $stable(dout));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dout == 8'h00));
endmodule

// File: tb/otp_bitarray_bench.sv
module otp_bitarray_bench;
    localparam int AW     = 10;
    localparam int PULSES = 3;
    localparam int NB     = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0, ce_n = 1'b1, rd_en = 1'b0, pgm_en = 1'b0;
    logic we_n = 1'b1, din = 1'b1, dle = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] dout;

    always #5 clk = ~clk;

    otp_bitarray #(.ADDR_W(AW), .PULSES(PULSES)) u_otp_bitarray (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rd_en(rd_en), .pgm_en(pgm_en),
        .we_n(we_n), .din(din), .dle(dle), .addr(addr), .dout(dout)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    bit       e_cells [NB];
    logic [7:0] e_dout = 8'h00;
    bit       e_data = 1'b1;
    int       e_cnt = 0;
    int       e_last = 0;

    function automatic logic [7:0] exp_byte(int b);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = e_cells[b*8 + k];
        return r;
    endfunction

    // Advance the model by one edge from the requirements.
    task automatic model_edge();
        int n;
        if (!rst_n) begin
            e_dout = 8'h00; e_data = 1'b1; e_cnt = 0; e_last = 0;
        end else if (!ce_n) begin
            if (rd_en && we_n) begin
                e_dout = exp_byte(int'(addr) >> 3);
            end else if (!rd_en && pgm_en && !we_n) begin
                if (!e_data) begin
                    n = (e_cnt != 0 && e_last == int'(addr)) ? e_cnt + 1 : 1;
                    if (n >= PULSES) begin
                        e_cells[addr] = 1'b0;
                        e_cnt = 0;
                    end else begin
                        e_cnt = n;
                    end
                end else begin
                    e_cnt = 0;
                end
                e_last = int'(addr);
            end
            if (dle) e_data = din;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
    endtask

    task automatic chk(logic [7:0] exp, string tag);
        checks++;
        if (dout !== exp) begin
            errors++;
            $display("FAIL %s: dout=%h expected %h", tag, dout, exp);
        end
    endtask

    task automatic setin(logic c, logic r, logic p, logic w, logic d, logic l, int a);
        ce_n = c; rd_en = r; pgm_en = p; we_n = w; din = d; dle = l; addr = AW'(a);
    endtask

    task automatic do_read(int a);   setin(0, 1, 0, 1, 0, 0, a); tick(); endtask
    task automatic do_idle();        setin(0, 0, 0, 1, 0, 0, 0); tick(); endtask
    task automatic do_latch(logic d); setin(0, 0, 0, 1, d, 1, 0); tick(); endtask
    task automatic do_pulses(int a, int n);
        for (int i = 0; i < n; i++) begin setin(0, 0, 1, 0, 0, 0, a); tick(); end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NB; i++) e_cells[i] = 1'b1;

        // R1: reset state of dout
        rst_n = 1'b0;
        tick(); tick();
        chk(8'h00, "R1 reset dout");
        rst_n = 1'b1;
        do_idle();

        // R2/R3: fresh byte reads FF one edge after read; low bits ignored
        do_read(5*8 + 5);
        chk(8'hFF, "R2 erased byte");
        do_idle();
        chk(8'hFF, "R4 hold after read");

        // R1: latch cleared by reset, pulses burn nothing
        do_pulses(0, PULSES);
        do_read(0);
        chk(8'hFF, "R1 latch reset to 1");

        // R7/R5: PULSES-1 pulses not enough, the next one burns bit 2 of byte 3
        do_latch(1'b0);
        do_pulses(26, PULSES - 1);
        do_read(24 + 7);
        chk(8'hFF, "R7 too few pulses");
        do_pulses(26, 1);
        do_read(24);
        chk(8'hFB, "R5 R7 bit mapping after burn");

        // R7: pulse to another address restarts the count
        do_pulses(80, 1); do_pulses(81, 1); do_pulses(80, PULSES - 1);
        do_read(80);
        chk(8'hFF, "R7 restart on other address");
        do_pulses(80, 1);
        do_read(80);
        chk(8'hFE, "R7 burn after uninterrupted run");

        // R6: strobe high inhibits programming
        for (int i = 0; i < PULSES; i++) begin setin(0, 0, 1, 1, 0, 0, 96); tick(); end
        do_read(96);
        chk(8'hFF, "R6 we_n high inhibits");
        // R6: read enable high with strobe low: no program, no read
        for (int i = 0; i < PULSES; i++) begin setin(0, 1, 1, 0, 0, 0, 24); tick(); end
        chk(8'hFF, "R6 rd_en high blocks read with we_n low");
        setin(0, 1, 1, 0, 0, 0, 96); tick(); tick(); tick();
        do_read(96);
        chk(8'hFF, "R6 rd_en high blocks program");

        // R10: standby ignores read, pulse and latch
        setin(1, 1, 0, 1, 0, 0, 24); tick();
        chk(8'hFF, "R10 standby read ignored");
        for (int i = 0; i < PULSES; i++) begin setin(1, 0, 1, 0, 0, 0, 96); tick(); end
        setin(1, 0, 0, 1, 1, 1, 0); tick();
        do_read(96);
        chk(8'hFF, "R10 standby pulses ignored");
        // R9: latched 0 still held (standby latch ignored), dle low ignores din
        setin(0, 0, 0, 1, 1, 0, 0); tick();
        do_pulses(97, PULSES);
        do_read(96);
        chk(8'hFD, "R9 R10 latch held through standby and dle low");

        // R8: latched 1 changes nothing; burned cell stays 0
        do_latch(1'b1);
        do_pulses(26, PULSES);
        do_pulses(27, PULSES);
        do_read(24);
        chk(8'hFB, "R8 latched 1 no effect");

        // R11/R1: reset keeps cells, clears latch
        rst_n = 1'b0; tick();
        chk(8'h00, "R1 reset dout again");
        rst_n = 1'b1;
        do_pulses(99, PULSES);
        do_read(24);
        chk(8'hFB, "R11 byte 3 kept through reset");
        do_read(96);
        chk(8'hFD, "R11 R1 byte 12 kept, no burn after reset");

        // Random phase, checked every cycle against the model
        begin
            int a = 0;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom % 4 == 0) a = int'($urandom % 64);
                setin(($urandom % 8) == 0, ($urandom % 3) == 0, ($urandom % 2) == 1,
                      ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 6) == 0, a);
                rst_n = ($urandom % 700) != 0;
                tick();
                chk(e_dout, "R3 random read/program mix");
            end
            rst_n = 1'b1;
        end
        for (int b = 0; b < 8; b++) begin
            do_read(b * 8);
            chk(exp_byte(b), "R8 final readback");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule